// File: doc/BRIEF.md
# Block-Write Configuration Slave for a Clock Generator

This block is a two-wire serial slave that holds the configuration of a system clock generator. A host writes it with a block transfer: device address, a command byte and a count byte (both acknowledged and thrown away), then up to six register bytes. The bytes land in register 0, then 1, and so on upward, with no register addressing. A read transfer returns a byte count followed by the six registers. SCL and SDA are sampled in the system clock domain, resynchronised and deglitched, and SDA is driven open-drain through a single pull-low output.

Register 0 controls the frequency selection and the spreading controls. A mode bit chooses between three strap pins that are captured once after reset and a three-bit code held in the register. Three further decoded outputs carry the spread enable, the output float request and a two-bit spread profile. The six registers are also brought out whole, so downstream logic can use the output-enable bits directly.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 8-bit write address D2h and read address D3h. Any other address receives no acknowledge, and the bus is ignored until the next start. An acknowledge holds SDA low through the ninth clock, and the slave changes its drive only while SCL is low.
- R2: In a write, the two bytes that follow the address are acknowledged and have no effect on any register.
- R3: The data bytes of a write are stored in order into register 0, 1, 2, up to register 5, and each one is acknowledged.
- R4: A stop after any complete data byte ends the write. Registers already written keep their new values and the others keep their previous values.
- R5: Data bytes after the sixth are acknowledged and discarded.
- R6: In a read, the slave sends MSB first the byte count 6, then registers 0 to 5, then FFh for any further byte. After the host answers a byte with no acknowledge, the slave releases SDA.
- R7: After reset, register 0 is 10h (bits 6:4 = 001, other bits 0) and registers 1 to 5 are FFh.
- R8: When register 0 bit 3 is 0, freqSel equals strapFs as sampled at the first clock after reset release. Later strap changes have no effect. When bit 3 is 1, freqSel equals register 0 bits 6:4.
- R9: spreadEn is register 0 bit 1, outTristate is register 0 bit 0, and spreadMode is {register 0 bit 7, register 0 bit 2}.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. For example, a one-clock low pulse on SDA while SCL is high creates neither a start nor a stop, and the transfer in progress continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| strapFs | input | 3 | Frequency-select strap pins, captured after reset |
| sdaDriveLow | output | 1 | High pulls SDA low (open-drain enable) |
| cfgRegs | output | NUM_BYTES*8 | Register k on bits 8k+7:8k |
| freqSel | output | 3 | Selected frequency code |
| spreadEn | output | 1 | Spread spectrum enable |
| outTristate | output | 1 | Request to float all clock outputs |
| spreadMode | output | 2 | Spread profile select |

## Verification
If the byte position counter goes wrong, the error shows up as a shifted or missing register value on cfgRegs within a few clocks of the byte's ninth SCL falling edge. On a read it shows up as the wrong byte on SDA at the very next transfer. If the bit counter or the state is corrupted, an acknowledge is missing, or SDA is pulled low during an SCL-high phase. The bench sees this in the same bit period, at the host's next sample. If the strap capture goes wrong, freqSel is wrong from the first cycle after reset. The deglitch filter is checked by a transfer that carries a one-clock SDA pulse. A false start there would push every later byte into the wrong register.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  // Width of the byte position counters; supports up to 2**IDX_W-2 registers.
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;

  // Strobes from the bus control to the register datapath.
  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
    logic [IDX_W-1:0]  rdIdx;   // 0 = byte count, k = register k-1
  } regStrobe_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;

  // Two-stage synchroniser, then the output follows only a level held FILT_LEN clocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      lineOut <= 1'b1;
      runCnt  <= '0;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      if (syncQ[1] == lineOut) begin
        runCnt <= '0;
      end else if (runCnt == CNT_LAST) begin
        lineOut <= syncQ[1];
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclF,
  input  logic             sdaF,
  input  logic [BYTE_W-1:0] rdByte,
  output regStrobe_t       strb,
  output logic             sdaLow
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} busState_t;

  busState_t        state;
  logic             sclPrev, sdaPrev;
  logic             sclRise, sclFall, startDet, stopDet;
  logic [7:0]       shReg;
  logic [6:0]       txSh;
  logic [3:0]       bitCnt;
  logic             addrPhase, isRead, hostAck;
  logic [1:0]       hdrLeft;
  logic [IDX_W-1:0] dataIdx, txIdx;
  logic             wrEnQ;
  logic [IDX_W-1:0] wrIdxQ;
  logic [7:0]       wrDataQ;

  assign sclRise  =  sclF & ~sclPrev;
  assign sclFall  = ~sclF &  sclPrev;
  assign startDet =  sclF &  sclPrev &  sdaPrev & ~sdaF;
  assign stopDet  =  sclF &  sclPrev & ~sdaPrev &  sdaF;

  assign strb.wrEn   = wrEnQ;
  assign strb.wrIdx  = wrIdxQ;
  assign strb.wrData = wrDataQ;
  assign strb.rdIdx  = txIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      shReg     <= '0;
      txSh      <= '0;
      bitCnt    <= '0;
      addrPhase <= 1'b0;
      isRead    <= 1'b0;
      hostAck   <= 1'b0;
      hdrLeft   <= '0;
      dataIdx   <= '0;
      txIdx     <= '0;
      wrEnQ     <= 1'b0;
      wrIdxQ    <= '0;
      wrDataQ   <= '0;
      sdaLow    <= 1'b0;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      wrEnQ   <= 1'b0;
      if (startDet) begin
        state     <= ST_RX;
        bitCnt    <= '0;
        addrPhase <= 1'b1;
        sdaLow    <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (addrPhase) begin
                if (shReg[7:1] == DEV_ADDR) begin
                  isRead    <= shReg[0];
                  addrPhase <= 1'b0;
                  hdrLeft   <= 2'd2;
                  dataIdx   <= '0;
                  txIdx     <= '0;
                  sdaLow    <= 1'b1;
                  state     <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaLow <= 1'b1;
                state  <= ST_RX_ACK;
                if (hdrLeft != 2'd0) begin
                  hdrLeft <= hdrLeft - 2'd1;
                end else begin
                  wrEnQ   <= 1'b1;
                  wrIdxQ  <= dataIdx;
                  wrDataQ <= shReg;
                  if (dataIdx != IDX_MAX) dataIdx <= dataIdx + 1'b1;
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                txSh   <= rdByte[6:0];
                sdaLow <= ~rdByte[7];
                if (txIdx != IDX_MAX) txIdx <= txIdx + 1'b1;
                state  <= ST_TX;
              end else begin
                sdaLow <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaLow <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sdaLow <= ~txSh[6];
                txSh   <= {txSh[5:0], 1'b0};
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (sclRise) begin
              hostAck <= ~sdaF;
            end else if (sclFall) begin
              if (hostAck) begin
                bitCnt <= '0;
                txSh   <= rdByte[6:0];
                sdaLow <= ~rdByte[7];
                if (txIdx != IDX_MAX) txIdx <= txIdx + 1'b1;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the slave may only move SDA while the filtered clock is low.
  p_drive_scl_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow != $past(sdaLow)) |-> !sclF);

  // R6: once idle (for example after a host no-acknowledge) SDA is released.
  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow);

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic [2:0]             strapFs,
  output logic [BYTE_W-1:0]      rdByte,
  output logic [NUM_BYTES*8-1:0] cfgRegs,
  output logic [2:0]             freqSel,
  output logic                   spreadEn,
  output logic                   outTristate,
  output logic [1:0]             spreadMode
);
  localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(NUM_BYTES);

  logic [NUM_BYTES-1:0][7:0] regQ;
  logic [2:0]                strapQ;
  logic                      strapDone;
  logic [7:0]                ctlByte;

  function automatic logic [7:0] resetVal(int k);
    return (k == 0) ? 8'h10 : 8'hFF;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_BYTES; k++) regQ[k] <= resetVal(k);
    end else if (strb.wrEn) begin
      for (int k = 0; k < NUM_BYTES; k++)
        if (strb.wrIdx == IDX_W'(k)) regQ[k] <= strb.wrData;
    end
  end

  // Strap pins are captured once, on the first clock after reset release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ    <= '0;
      strapDone <= 1'b0;
    end else if (!strapDone) begin
      strapQ    <= strapFs;
      strapDone <= 1'b1;
    end
  end

  always_comb begin
    rdByte = 8'hFF;
    if (strb.rdIdx == '0) rdByte = 8'(NUM_BYTES);
    for (int k = 0; k < NUM_BYTES; k++)
      if (strb.rdIdx == IDX_W'(k + 1)) rdByte = regQ[k];
  end

  generate
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
      assign cfgRegs[g*8 +: 8] = regQ[g];
    end
  endgenerate

  assign ctlByte     = regQ[0];
  assign freqSel     = ctlByte[3] ? ctlByte[6:4] : strapQ;
  assign spreadEn    = ctlByte[1];
  assign outTristate = ctlByte[0];
  assign spreadMode  = {ctlByte[7], ctlByte[2]};

  // R5: a write strobe past the last register leaves every register unchanged.
  p_extra_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrIdx >= LIMIT_IDX) |=> $stable(regQ));

  // R8: after capture the strap copy never moves.
  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strapDone && $past(strapDone)) |-> $stable(strapQ));

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_BYTES = 6,
  parameter int         FILT_LEN  = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h69
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [2:0]             strapFs,
  output logic                   sdaDriveLow,
  output logic [NUM_BYTES*8-1:0] cfgRegs,
  output logic [2:0]             freqSel,
  output logic                   spreadEn,
  output logic                   outTristate,
  output logic [1:0]             spreadMode
);
  logic [1:0]  rawLines, filtLines;
  regStrobe_t  strb;
  logic [7:0]  rdByte;

  assign rawLines = {sclIn, sdaIn};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_filt
      i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rstN    (rstN),
        .lineIn  (rawLines[i]),
        .lineOut (filtLines[i])
      );
    end
  endgenerate

  i2c_cfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclF   (filtLines[1]),
    .sdaF   (filtLines[0]),
    .rdByte (rdByte),
    .strb   (strb),
    .sdaLow (sdaDriveLow)
  );

  i2c_cfg_regs #(.NUM_BYTES(NUM_BYTES)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .strapFs     (strapFs),
    .rdByte      (rdByte),
    .cfgRegs     (cfgRegs),
    .freqSel     (freqSel),
    .spreadEn    (spreadEn),
    .outTristate (outTristate),
    .spreadMode  (spreadMode)
  );
endmodule

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        sclH = 1'b1, sdaH = 1'b1;
  logic [2:0]  strapFs = 3'b101;
  logic        sdaDriveLow;
  logic [47:0] cfgRegs;
  logic [2:0]  freqSel;
  logic        spreadEn, outTristate;
  logic [1:0]  spreadMode;
  wire         sdaLine = sdaH & ~sdaDriveLow;

  i2c_cfg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclH), .sdaIn(sdaLine), .strapFs(strapFs),
    .sdaDriveLow(sdaDriveLow), .cfgRegs(cfgRegs), .freqSel(freqSel),
    .spreadEn(spreadEn), .outTristate(outTristate), .spreadMode(spreadMode));

  int checks = 0, fails = 0;
  logic [7:0] model [6];
  logic [7:0] wbuf [10];
  logic [7:0] expQ [$];
  logic [7:0] actQ [$];
  string      tagQ [$];
  bit         done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read-back bytes against expected ones.
  initial forever begin
    wait (actQ.size() > 0);
    begin
      logic [7:0] a, e;
      string t;
      a = actQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(a == e, t, 32'(a), 32'(e));
    end
  end

  task automatic qdel();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaH = 1; sclH = 1; qdel(); sdaH = 0; qdel(); sclH = 0; qdel();
  endtask

  task automatic busStop();
    sdaH = 0; qdel(); sclH = 1; qdel(); sdaH = 1; qdel();
  endtask

  task automatic writeBit(input bit b);
    sdaH = b; qdel(); sclH = 1; qdel(); qdel(); sclH = 0; qdel();
  endtask

  // A '1' bit with a one-clock low pulse on SDA while SCL is high.
  task automatic writeBitGlitch();
    sdaH = 1; qdel(); sclH = 1; qdel();
    @(negedge clk) sdaH = 0;
    @(negedge clk) sdaH = 1;
    qdel(); sclH = 0; qdel();
  endtask

  task automatic readBit(output bit b);
    sdaH = 1; qdel(); sclH = 1; qdel(); b = sdaLine; qdel(); sclH = 0; qdel();
  endtask

  task automatic sendByte(input logic [7:0] d, input bit glitch, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      if (glitch && i == 7 && d[7]) writeBitGlitch();
      else writeBit(d[i]);
    end
    readBit(s);
    ack = !s;
  endtask

  task automatic recvByte(output logic [7:0] d, input bit ackIt);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    writeBit(!ackIt);
  endtask

  task automatic chkRegs(input string tag);
    for (int k = 0; k < 6; k++)
      chk(cfgRegs[k*8 +: 8] == model[k], tag, 32'(cfgRegs[k*8 +: 8]), 32'(model[k]));
  endtask

  task automatic doWrite(input int n, input bit glitch, input string tag);
    bit ack;
    busStart();
    sendByte(8'hD2, 0, ack);  chk(ack, "R1 write address ack", 32'(ack), 1);
    sendByte(8'h3C, 0, ack);  chk(ack, "R2 command byte ack", 32'(ack), 1);
    sendByte(8'h77, 0, ack);  chk(ack, "R2 count byte ack", 32'(ack), 1);
    repeat (10) @(negedge clk);
    chkRegs("R2 header bytes leave registers");
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], glitch && i == 0, ack);
      chk(ack, (i < 6) ? "R3 data byte ack" : "R5 extra byte ack", 32'(ack), 1);
      if (i < 6) model[i] = wbuf[i];
    end
    busStop();
    repeat (10) @(negedge clk);
    chkRegs(tag);
  endtask

  task automatic doRead(input int n);
    bit ack;
    logic [7:0] d;
    busStart();
    sendByte(8'hD3, 0, ack);
    chk(ack, "R1 read address ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      expQ.push_back((i == 0) ? 8'd6 : (i <= 6) ? model[i-1] : 8'hFF);
      tagQ.push_back("R6 read-back byte");
      recvByte(d, i < n - 1);
      actQ.push_back(d);
    end
    chk(sdaDriveLow == 0, "R6 SDA released after host NACK", 32'(sdaDriveLow), 0);
    busStop();
  endtask

  initial begin
    repeat (1900000 / 10) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    model[0] = 8'h10;
    for (int k = 1; k < 6; k++) model[k] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    chkRegs("R7 reset defaults");
    chk(freqSel == 3'b101, "R8 strap selects frequency", 32'(freqSel), 5);
    chk(spreadEn == 0 && outTristate == 0, "R9 reset decode", 32'({spreadEn, outTristate}), 0);
    chk(spreadMode == 2'b00, "R9 reset spread mode", 32'(spreadMode), 0);
    strapFs = 3'b010;
    repeat (5) @(negedge clk);
    chk(freqSel == 3'b101, "R8 late strap change ignored", 32'(freqSel), 5);

    // Full write, register code selects frequency.
    wbuf[0] = 8'hBF; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    wbuf[3] = 8'h33; wbuf[4] = 8'h44; wbuf[5] = 8'h55;
    doWrite(6, 0, "R3 full write stored in order");
    chk(freqSel == 3'b011, "R8 register code selects frequency", 32'(freqSel), 3);
    chk(spreadEn == 1 && outTristate == 1, "R9 enable and float bits", 32'({spreadEn, outTristate}), 3);
    chk(spreadMode == 2'b11, "R9 spread mode bits 7 and 2", 32'(spreadMode), 3);

    // Partial write ending after two data bytes.
    wbuf[0] = 8'h04; wbuf[1] = 8'h5A;
    doWrite(2, 0, "R4 partial write keeps others");
    chk(freqSel == 3'b101, "R8 back to captured strap", 32'(freqSel), 5);
    chk(spreadMode == 2'b01, "R9 spread mode 01", 32'(spreadMode), 1);
    chk(spreadEn == 0 && outTristate == 0, "R9 decode cleared", 32'({spreadEn, outTristate}), 0);

    // Overlong write.
    wbuf[0] = 8'h58; wbuf[1] = 8'hA1; wbuf[2] = 8'hB2; wbuf[3] = 8'hC3;
    wbuf[4] = 8'hD4; wbuf[5] = 8'hE5; wbuf[6] = 8'hF6; wbuf[7] = 8'h07;
    doWrite(8, 0, "R5 extra bytes discarded");
    chk(freqSel == 3'b101, "R8 register code 101", 32'(freqSel), 5);

    // Foreign address.
    busStart();
    sendByte(8'hA4, 0, ack); chk(!ack, "R1 foreign address not acked", 32'(ack), 0);
    sendByte(8'h00, 0, ack); chk(!ack, "R1 bus ignored after mismatch", 32'(ack), 0);
    busStop();
    repeat (10) @(negedge clk);
    chkRegs("R1 foreign address changes nothing");

    doRead(8);

    // Deglitch: a one-clock SDA pulse during SCL high must not break the write.
    wbuf[0] = 8'hA5;
    doWrite(1, 1, "R10 glitch ignored");
    chk(spreadMode == 2'b11 && outTristate == 1, "R10 decoded after glitch", 32'({spreadMode, outTristate}), 7);
    chk(freqSel == 3'b101, "R10 strap path after glitch", 32'(freqSel), 5);

    doRead(7);

    wait (actQ.size() == 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule